// File: doc/BRIEF.md
# Chroma Colour Transient Improver

This block sharpens horizontal edges in a pair of colour-difference streams. Each channel keeps a short history of samples around a centre sample. The sign of the discrete second derivative at the centre tells which side of an edge's inflection point the sample lies on. Samples before the inflection are pulled toward the local minimum of the window and samples after it toward the local maximum, or the reverse for a falling edge. The edge therefore steepens symmetrically about its original inflection point and does not move in time.

Three static controls shape the correction. A 2-bit length field sets the half-width of the search window. A 2-bit gain field sets how far each sample moves toward its target. A detail-protection bit turns the correction off where the window holds fine colour texture rather than a single transition. The two channels use the same controls and the same timing, but each computes its own window and derivatives. Samples arrive with a valid strobe at the chroma rate, and idle cycles between them are allowed.

Top module: `chroma_cti`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, valid_o is 0 and u_o and v_o are 0. All history samples reset to 0.
- R2: valid_o is high exactly in the clock cycle after a cycle with valid_i high. The sample then shown is the centre sample, which is the input accepted MAX_HALF (default 4) valid samples earlier. With no correction, that centre sample passes through unchanged.
- R3: Samples are signed two's complement. Let c be the centre sample, p the sample before it and n the sample after it, and let d2 = p + n - 2c. If d2 > 0 the target is the window minimum. If d2 < 0 the target is the window maximum. If d2 = 0 the output is c.
- R4: The window spans len_sel_i+1 samples on each side of the centre, so its half-width is 1 to 4.
- R5: The output is c + floor((target - c) * (gain_sel_i + 1) / 4). With gain_sel_i = 3 the output equals the target.
- R6: Every output lies between the minimum and the maximum of the current window, inclusive.
- R7: Adjacent samples in the window give first differences. A sign change is a pair of consecutive differences where one is strictly positive and the other strictly negative. A zero difference counts as neither sign. If detail_i is 1 and the window holds more than one sign change, the output is c.
- R8: The U and V channels are computed independently. A flat channel stays at its level while the other channel carries an edge.
- R9: A cycle with valid_i low does not advance the history and drives valid_o low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| u_i | input | DATA_W | U sample, signed |
| v_i | input | DATA_W | V sample, signed |
| len_sel_i | input | 2 | Window half-width minus one |
| gain_sel_i | input | 2 | Correction strength, (value+1)/4 |
| detail_i | input | 1 | Fine-detail protection enable |
| valid_o | output | 1 | Output sample strobe |
| u_o | output | DATA_W | Improved U sample, signed |
| v_o | output | DATA_W | Improved V sample, signed |

## Verification
The hardest case to reach is the detail-protection cut-off. It needs a window whose first differences change sign at least twice while the centre still has a nonzero second derivative, so that the protection changes the result. A zig-zag that also climbs (0, 12, 4, 16, 8, ...) does this. The bench sends it with protection on and then with it off, and compares the two. Edges at different lengths and gains, and full-scale steps at -128/127, reach the window-limit cases.

// File: rtl/chroma_cti_pkg.sv
package chroma_cti_pkg;
  typedef logic [1:0] sel_t;

  function automatic logic signed [3:0] gain_factor(sel_t s);
    return $signed({2'b00, s}) + 4'sd1;
  endfunction
endpackage

// File: rtl/chroma_cti_taps.sv
module chroma_cti_taps #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [DATA_W-1:0]       sample_i,
  output logic [DEPTH*DATA_W-1:0] taps_o
);
  logic [DEPTH*DATA_W-1:0] taps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      taps_q <= '0;
    else if (valid_i) taps_q <= {taps_q[(DEPTH-1)*DATA_W-1:0], sample_i};
  end

  assign taps_o = taps_q;

  // R9: history frozen on idle cycles
  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(taps_q));
endmodule

// File: rtl/chroma_cti_core.sv
module chroma_cti_core
  import chroma_cti_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_HALF = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [(2*MAX_HALF+1)*DATA_W-1:0]   taps_i,
  input  sel_t                               len_sel_i,
  input  sel_t                               gain_sel_i,
  input  logic                               detail_i,
  output logic [DATA_W-1:0]                  out_o
);
  localparam int DEPTH = 2*MAX_HALF + 1;
  localparam int DW    = DATA_W + 2;
  localparam int PW    = DATA_W + 5;

  logic signed [DATA_W-1:0] tap [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    assign tap[i] = taps_i[i*DATA_W +: DATA_W];
  end

  logic signed [DATA_W-1:0] ctr, win_max, win_min, target, res_s;
  logic signed [DW-1:0]     d2;
  logic signed [PW-1:0]     diff, prod, res;
  logic [3:0]               flips;
  logic                     bypass;
  int                       lo_idx, hi_idx;

  assign ctr = tap[MAX_HALF];
  assign d2  = DW'(tap[MAX_HALF-1]) + DW'(tap[MAX_HALF+1]) - (DW'(ctr) <<< 1);

  always_comb begin
    lo_idx  = MAX_HALF - (int'(len_sel_i) + 1);
    hi_idx  = MAX_HALF + (int'(len_sel_i) + 1);
    win_max = ctr;
    win_min = ctr;
    for (int i = 0; i < DEPTH; i++) begin
      if (i >= lo_idx && i <= hi_idx) begin
        if (tap[i] > win_max) win_max = tap[i];
        if (tap[i] < win_min) win_min = tap[i];
      end
    end
  end

  // sign changes of the first difference inside the window
  always_comb begin
    logic signed [DATA_W:0] da, db;
    flips = '0;
    for (int i = 0; i < DEPTH-2; i++) begin
      da = (DATA_W+1)'(tap[i])   - (DATA_W+1)'(tap[i+1]);
      db = (DATA_W+1)'(tap[i+1]) - (DATA_W+1)'(tap[i+2]);
      if (i >= lo_idx && i + 2 <= hi_idx &&
          ((da > 0 && db < 0) || (da < 0 && db > 0)))
        flips = flips + 4'd1;
    end
  end

  assign bypass = detail_i && (flips > 4'd1);

  always_comb begin
    if (d2 > 0)      target = win_min;
    else if (d2 < 0) target = win_max;
    else             target = ctr;
    diff = PW'(target) - PW'(ctr);
    prod = diff * PW'(gain_factor(gain_sel_i));
    res  = PW'(ctr) + (prod >>> 2);
  end

  assign res_s = bypass ? ctr : res[DATA_W-1:0];
  assign out_o = res_s;

  a_r6_within_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_s >= win_min && res_s <= win_max);
  a_r3_flat_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d2 == 0 |-> res_s == ctr);
  a_r7_detail_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detail_i && flips > 4'd1) |-> res_s == ctr);
  a_r5_full_gain_hits_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_sel_i == 2'd3 && !bypass && d2 > 0) |-> res_s == win_min);
endmodule

// File: rtl/chroma_cti.sv
module chroma_cti
  import chroma_cti_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_HALF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] u_i,
  input  logic [DATA_W-1:0] v_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        gain_sel_i,
  input  logic              detail_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] u_o,
  output logic [DATA_W-1:0] v_o
);
  localparam int DEPTH = 2*MAX_HALF + 1;
  localparam int NCH   = 2;

  logic [DATA_W-1:0] ch_in  [NCH];
  logic [DATA_W-1:0] ch_out [NCH];

  assign ch_in[0] = u_i;
  assign ch_in[1] = v_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DEPTH*DATA_W-1:0] taps;
    chroma_cti_taps #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_taps (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
      .sample_i(ch_in[c]), .taps_o(taps));
    chroma_cti_core #(.DATA_W(DATA_W), .MAX_HALF(MAX_HALF)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .taps_i(taps),
      .len_sel_i(len_sel_i), .gain_sel_i(gain_sel_i), .detail_i(detail_i),
      .out_o(ch_out[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign u_o = ch_out[0];
  assign v_o = ch_out[1];

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: tb/sim_chroma_cti.sv
`timescale 1ns/1ps
module sim_chroma_cti;
  localparam int W  = 8;
  localparam int MH = 4;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, detail_i = 1'b0;
  logic [W-1:0] u_i = '0, v_i = '0;
  logic [1:0] len_sel_i = '0, gain_sel_i = '0;
  logic valid_o;
  logic [W-1:0] u_o, v_o;

  int hist [2][256];
  int n = 0, total = 0, bad = 0;

  always #2.5 clk = ~clk;

  chroma_cti #(.DATA_W(W), .MAX_HALF(MH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .u_i(u_i), .v_i(v_i),
    .len_sel_i(len_sel_i), .gain_sel_i(gain_sel_i), .detail_i(detail_i),
    .valid_o(valid_o), .u_o(u_o), .v_o(v_o));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int smp(int ch, int k);
    return (k < 0) ? 0 : hist[ch][k];
  endfunction

  function automatic int wmin(int ch);
    int c = n - 1 - MH, h = int'(len_sel_i) + 1, m = smp(ch, c);
    for (int k = c - h; k <= c + h; k++) if (smp(ch, k) < m) m = smp(ch, k);
    return m;
  endfunction

  function automatic int wmax(int ch);
    int c = n - 1 - MH, h = int'(len_sel_i) + 1, m = smp(ch, c);
    for (int k = c - h; k <= c + h; k++) if (smp(ch, k) > m) m = smp(ch, k);
    return m;
  endfunction

  function automatic int model(int ch);
    int c = n - 1 - MH, h = int'(len_sel_i) + 1;
    int cv = smp(ch, c), d2, t, fl = 0;
    d2 = smp(ch, c - 1) + smp(ch, c + 1) - 2 * cv;
    for (int k = c - h; k <= c + h - 2; k++) begin
      int a = smp(ch, k + 1) - smp(ch, k);
      int b = smp(ch, k + 2) - smp(ch, k + 1);
      if ((a > 0 && b < 0) || (a < 0 && b > 0)) fl++;
    end
    if (detail_i && fl > 1) return cv;
    t = (d2 > 0) ? wmin(ch) : (d2 < 0) ? wmax(ch) : cv;
    return cv + (((t - cv) * (int'(gain_sel_i) + 1)) >>> 2);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0; n = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive one sample, check the output one clock later
  task automatic push(int u, int v, string req);
    int uo, vo;
    @(negedge clk);
    valid_i = 1'b1; u_i = u[W-1:0]; v_i = v[W-1:0];
    hist[0][n] = u; hist[1][n] = v; n++;
    @(negedge clk);
    valid_i = 1'b0;
    uo = int'($signed(u_o)); vo = int'($signed(v_o));
    chk({req, " R2 valid"}, int'(valid_o), 1);
    chk({req, " u"}, uo, model(0));
    chk({req, " v"}, vo, model(1));
    chk("R6 u in window", int'(uo >= wmin(0) && uo <= wmax(0)), 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 u", int'(u_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 v after release", int'(v_o), 0);
  endtask

  task automatic t_ramp();
    len_sel_i = 2'd1; gain_sel_i = 2'd3; detail_i = 1'b0;
    do_reset();
    for (int k = 0; k < 16; k++) push(k * 8, -k * 4, "R2 ramp");
    chk("R2 ramp delayed", int'($signed(u_o)), smp(0, n - 1 - MH));
  endtask

  task automatic t_edge_gain();
    int seq [14] = '{-60,-60,-60,-60,-60,-30,0,30,60,60,60,60,60,60};
    for (int g = 0; g < 4; g++) begin
      len_sel_i = 2'd1; gain_sel_i = g[1:0]; detail_i = 1'b0;
      do_reset();
      foreach (seq[k]) push(seq[k], 0, "R3 R5 edge gain");
    end
  endtask

  task automatic t_edge_len();
    int seq [14] = '{-60,-60,-60,-60,-60,-30,0,30,60,60,60,60,60,60};
    for (int l = 0; l < 4; l++) begin
      len_sel_i = l[1:0]; gain_sel_i = 2'd3; detail_i = 1'b0;
      do_reset();
      foreach (seq[k]) push(0, seq[k], "R4 edge length");
    end
  endtask

  task automatic t_detail();
    int seq [14] = '{0,12,4,16,8,20,12,24,16,28,20,32,24,36};
    for (int d = 1; d >= 0; d--) begin
      len_sel_i = 2'd2; gain_sel_i = 2'd3; detail_i = d[0];
      do_reset();
      foreach (seq[k]) push(seq[k], 0, "R7 detail");
      if (d == 1) chk("R7 bypass keeps centre", int'($signed(u_o)), smp(0, n - 1 - MH));
    end
  endtask

  task automatic t_indep();
    len_sel_i = 2'd3; gain_sel_i = 2'd2; detail_i = 1'b1;
    do_reset();
    for (int k = 0; k < 14; k++) push((k < 7) ? -128 : 127, 30, "R8 indep");
    chk("R8 flat v", int'($signed(v_o)), 30);
  endtask

  task automatic t_idle();
    logic [W-1:0] held;
    len_sel_i = 2'd0; gain_sel_i = 2'd1; detail_i = 1'b0;
    do_reset();
    for (int k = 0; k < 8; k++) push(k * k, 5 - k, "R9 pre");
    held = u_o;
    repeat (3) @(negedge clk);
    chk("R9 valid low on idle", int'(valid_o), 0);
    chk("R9 output held on idle", int'(u_o), int'(held));
    for (int k = 8; k < 12; k++) push(k * k - 40, 5 - k, "R9 after gap");
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_edge_gain();
    t_edge_len();
    t_detail();
    t_indep();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule